// File: doc/BRIEF.md
# Bus-Hold Word DMA Engine

This block is a single-channel DMA engine. It moves a block of words between one peripheral device and memory, one word at a time. Software loads a start address, a direction and a block length. The length is written as a two's-complement count. Each time the device signals that a word is ready, the engine raises a request flag and asks the CPU for the bus. When the CPU grants the bus, the engine moves the word through a one-word holding register and acknowledges the device. It then releases the bus and waits for the grant to go away.

The word counter counts upward from the negated length. The carry out of its top bit marks the last word of the block. That carry disarms the channel and sets a sticky completion interrupt. The interrupt stays set until software clears it or a new block is loaded. Device strobes that arrive while no block is armed have no effect on the bus, the memory or the device.

Top module: `bushold_dma`

## Requirements
- R1: After a synchronous reset, `bus_hold`, `dev_ack`, `mem_wr`, `mem_rd`, `busy` and `irq` are all 0, and `mem_addr` is 0.
- R2: A `cfg_load` pulse accepted while the engine is idle does the following from the next cycle: `mem_addr` shows the loaded start address, `busy` reads 1 and `irq` reads 0.
- R3: A device strobe on an armed channel sets the request flag, and the engine then raises `bus_hold`. No memory access and no `dev_ack` occur until `bus_grant` has been seen high while `bus_hold` is up.
- R4: With `cfg_dir` = 0 (device to memory), the word on `dev_wdata` in the strobe cycle is captured in the holding register. It is then written once with `mem_wr` to the address start+k, where k counts the words already moved.
- R5: With `cfg_dir` = 1 (memory to device), the engine pulses `mem_rd` at address start+k. It takes `mem_rdata` on the following cycle and presents that word on `dev_rdata` while `dev_ack` is high.
- R6: Each word produces exactly one single-cycle `dev_ack`, and `mem_wr`, `mem_rd` and `dev_ack` are never high together. After each acknowledge, `mem_addr` advances by one, modulo 2^AW.
- R7: `bus_hold` drops in the cycle after `dev_ack`. It is not raised again while `bus_grant` is still high.
- R8: `cfg_cnt` is loaded with the two's complement of the word count N, modulo 2^CW. After exactly N words the counter carries out of its top bit, `irq` goes to 1 and `busy` goes to 0. A loaded value of 0 moves 2^CW words.
- R9: `irq` stays at 1 until an `irq_clr` pulse or a new `cfg_load` clears it.
- R10: A device strobe while no block is armed (after reset or after completion) is ignored. `bus_hold`, `dev_ack`, `mem_wr` and `mem_rd` stay 0, and `mem_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load start address, count and direction (accepted when idle) |
| cfg_dir | input | 1 | 0 = device to memory, 1 = memory to device |
| cfg_addr | input | AW | First memory address of the block |
| cfg_cnt | input | CW | Two's complement of the word count |
| irq_clr | input | 1 | Clears the completion interrupt |
| dev_strobe | input | 1 | Device has a word ready |
| dev_wdata | input | DW | Word from the device (device to memory) |
| dev_ack | output | 1 | One-cycle acknowledge to the device per word |
| dev_rdata | output | DW | Word for the device (holding register) |
| bus_hold | output | 1 | Bus request to the CPU |
| bus_grant | input | 1 | Bus grant from the CPU |
| mem_addr | output | AW | Current memory address |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe; data returns next cycle |
| mem_wdata | output | DW | Word written to memory (holding register) |
| mem_rdata | input | DW | Word read from memory |
| busy | output | 1 | A block is armed and not yet finished |
| irq | output | 1 | Sticky block-complete interrupt |

## Verification
A wrong address counter shows up in the first word that lands at or comes from the wrong location. It also shows up in `mem_addr` just after the last acknowledge. A wrong word counter shows up at the end of the block: `irq` and `busy` change one word too early or too late, or never change at all. That is why full-length blocks and single-word blocks both matter.

A request flag that does not clear, or a sequencer that ignores the grant, shows up within a few cycles of one word. It appears as an extra acknowledge, a memory strobe without a grant, or a bus request raised while the old grant is still up.

// File: rtl/bhd_pkg.sv
`timescale 1ns/1ps
package bhd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WR,
    ST_RD,
    ST_CAP,
    ST_ACK,
    ST_REL
  } bhd_state_t;

  typedef enum logic {
    DIR_IN  = 1'b0,
    DIR_OUT = 1'b1
  } bhd_dir_t;
endpackage

// File: rtl/bhd_addr_ctr.sv
`timescale 1ns/1ps
module bhd_addr_ctr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= addr + ONE;
  end
endmodule

// File: rtl/bhd_word_ctr.sv
`timescale 1ns/1ps
module bhd_word_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic          wrap
);
  localparam int SW = CW + 1;

  logic [CW-1:0] cnt;
  logic [SW-1:0] sum;

  always_comb begin
    sum  = {1'b0, cnt} + SW'(1);
    wrap = step && sum[CW];
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (step) cnt <= sum[CW-1:0];
  end

  // The cycle after a carry, the count has rolled over to zero.
  p_wrap_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (wrap && !load) |=> (cnt == '0));
endmodule

// File: rtl/bhd_seq.sv
`timescale 1ns/1ps
module bhd_seq
  import bhd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic req_flag,
  input  logic bus_grant,
  input  logic dir_out,
  output logic idle,
  output logic cap_en,
  output logic bus_hold,
  output logic mem_wr,
  output logic mem_rd,
  output logic dev_ack
);
  bhd_state_t st, st_n;

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE: if (armed && req_flag) st_n = ST_REQ;
      ST_REQ:  if (bus_grant) st_n = dir_out ? ST_RD : ST_WR;
      ST_WR:   st_n = ST_ACK;
      ST_RD:   st_n = ST_CAP;
      ST_CAP:  st_n = ST_ACK;
      ST_ACK:  st_n = ST_REL;
      ST_REL:  if (!bus_grant) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_comb begin
    idle   = (st == ST_IDLE);
    cap_en = (st == ST_CAP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bus_hold <= 1'b0;
      mem_wr   <= 1'b0;
      mem_rd   <= 1'b0;
      dev_ack  <= 1'b0;
    end else begin
      st       <= st_n;
      bus_hold <= (st_n == ST_REQ) || (st_n == ST_WR) || (st_n == ST_RD) ||
                  (st_n == ST_CAP) || (st_n == ST_ACK);
      mem_wr   <= (st_n == ST_WR);
      mem_rd   <= (st_n == ST_RD);
      dev_ack  <= (st_n == ST_ACK);
    end
  end

  // R3: a memory strobe starts only after the grant was sampled high.
  p_grant_seen_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_wr) || $rose(mem_rd)) |-> $past(bus_grant));
  // R6: at most one move strobe at a time; acknowledge is one cycle wide.
  p_one_move_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_wr, mem_rd, dev_ack}));
  p_ack_single_r6: assert property (@(posedge clk) disable iff (rst)
    dev_ack |=> !dev_ack);
  // R7: hold is released after the acknowledge and stays low while the grant lingers.
  p_hold_drop_r7: assert property (@(posedge clk) disable iff (rst)
    dev_ack |=> !bus_hold);
  p_rel_wait_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_REL && bus_grant) |=> !bus_hold);
endmodule

// File: rtl/bushold_dma.sv
`timescale 1ns/1ps
module bushold_dma
  import bhd_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_load,
  input  logic          cfg_dir,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_cnt,
  input  logic          irq_clr,
  input  logic          dev_strobe,
  input  logic [DW-1:0] dev_wdata,
  output logic          dev_ack,
  output logic [DW-1:0] dev_rdata,
  output logic          bus_hold,
  input  logic          bus_grant,
  output logic [AW-1:0] mem_addr,
  output logic          mem_wr,
  output logic          mem_rd,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          irq
);
  logic     armed, req_flag, irq_q;
  bhd_dir_t dir_q;
  logic [DW-1:0] hold_buf;
  logic     idle, cap_en, wrap, load_ok, accept;

  assign load_ok = cfg_load && idle;
  assign accept  = dev_strobe && armed && !req_flag;

  bhd_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .armed    (armed),
    .req_flag (req_flag),
    .bus_grant(bus_grant),
    .dir_out  (dir_q == DIR_OUT),
    .idle     (idle),
    .cap_en   (cap_en),
    .bus_hold (bus_hold),
    .mem_wr   (mem_wr),
    .mem_rd   (mem_rd),
    .dev_ack  (dev_ack)
  );

  bhd_addr_ctr #(.AW(AW)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .load    (load_ok),
    .load_val(cfg_addr),
    .step    (dev_ack),
    .addr    (mem_addr)
  );

  bhd_word_ctr #(.CW(CW)) u_words (
    .clk     (clk),
    .rst     (rst),
    .load    (load_ok),
    .load_val(cfg_cnt),
    .step    (dev_ack),
    .wrap    (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      req_flag <= 1'b0;
      irq_q    <= 1'b0;
      dir_q    <= DIR_IN;
    end else begin
      if (load_ok) begin
        armed <= 1'b1;
        dir_q <= bhd_dir_t'(cfg_dir);
      end else if (wrap) begin
        armed <= 1'b0;
      end

      if (load_ok)      req_flag <= 1'b0;
      else if (dev_ack) req_flag <= 1'b0;
      else if (accept)  req_flag <= 1'b1;

      if (load_ok)      irq_q <= 1'b0;
      else if (wrap)    irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                           hold_buf <= '0;
    else if (accept && dir_q == DIR_IN) hold_buf <= dev_wdata;
    else if (cap_en)                   hold_buf <= mem_rdata;
  end

  assign dev_rdata = hold_buf;
  assign mem_wdata = hold_buf;
  assign busy      = armed;
  assign irq       = irq_q;

  // R6: each acknowledge advances the address by one.
  p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
    dev_ack |=> (mem_addr == $past(mem_addr) + AW'(1)));
  // R8: the interrupt only rises right after a word was acknowledged.
  p_irq_on_last_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(dev_ack));
  // R9: the interrupt is sticky.
  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr && !cfg_load) |=> irq);
  // R10: with no block armed and the bus released, no request appears.
  p_ignore_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !bus_hold && !cfg_load) |=> !bus_hold);
endmodule

// File: tb/bushold_dma_bench.sv
`timescale 1ns/1ps
module bushold_dma_bench;
  localparam int AW = 8;
  localparam int CW = 8;
  localparam int DW = 16;
  localparam int MEMN = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst, cfg_load, cfg_dir, irq_clr, dev_strobe, bus_grant;
  logic [AW-1:0] cfg_addr;
  logic [CW-1:0] cfg_cnt;
  logic [DW-1:0] dev_wdata, mem_rdata;
  logic          dev_ack, bus_hold, mem_wr, mem_rd, busy, irq;
  logic [DW-1:0] dev_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;

  bushold_dma #(.AW(AW), .CW(CW), .DW(DW)) u_bushold_dma (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_dir(cfg_dir),
    .cfg_addr(cfg_addr), .cfg_cnt(cfg_cnt), .irq_clr(irq_clr),
    .dev_strobe(dev_strobe), .dev_wdata(dev_wdata), .dev_ack(dev_ack),
    .dev_rdata(dev_rdata), .bus_hold(bus_hold), .bus_grant(bus_grant),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .irq(irq)
  );

  int errors = 0;
  int checks = 0;
  logic [15:0] salt_q = 16'h0;

  function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a, input logic [15:0] s);
    return DW'(32'(a) * 32'h9E37 ^ 32'(s));
  endfunction
  function automatic logic [DW-1:0] data_fn(input int k, input logic [15:0] s);
    return DW'(k * 32'h2F1 + 32'(s) + 1);
  endfunction
  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] st, input int k);
    return AW'(32'(st) + k);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model: write array for device-to-memory; read data computed from address and salt.
  logic [DW-1:0] memw [MEMN];
  always @(posedge clk) begin
    if (mem_wr) memw[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem_fn(mem_addr, salt_q);
  end

  // Monitor: acknowledge log and protocol checks, sampled after the edge settles.
  int ack_cnt = 0;
  int proto_err = 0;
  logic [DW-1:0] rd_log [1024];
  logic hold_prev = 1'b0, ack_prev = 1'b0;
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if ((mem_wr || mem_rd || dev_ack) && !bus_grant) proto_err++;  // R3
      if (bus_hold && !hold_prev && bus_grant) proto_err++;            // R7
      if (dev_ack && ack_prev) proto_err++;                            // R6
      if (dev_ack) begin
        rd_log[ack_cnt % 1024] = dev_rdata;
        ack_cnt++;
      end
    end
    hold_prev = bus_hold;
    ack_prev  = dev_ack;
  end

  // CPU model: grants after a random delay, drops the grant after hold falls.
  initial begin
    int d;
    bus_grant = 1'b0;
    d = 0;
    forever begin
      @(negedge clk);
      if (bus_hold && !bus_grant) begin
        if (d == 0) begin bus_grant = 1'b1; d = $urandom % 4; end
        else d--;
      end else if (!bus_hold && bus_grant) begin
        if (d == 0) begin bus_grant = 1'b0; d = $urandom % 4; end
        else d--;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy || bus_hold || bus_grant || dev_ack);
    repeat (2) @(negedge clk);
  endtask

  task automatic strobe_word(input logic [DW-1:0] d);
    @(negedge clk);
    dev_strobe = 1'b1; dev_wdata = d;
    @(negedge clk);
    dev_strobe = 1'b0;
  endtask

  task automatic ignored_strobes(input string tag);
    logic [AW-1:0] a0;
    int bad;
    a0 = mem_addr; bad = 0;
    strobe_word(16'hDEAD);
    repeat (10) begin
      @(negedge clk);
      if (bus_hold || dev_ack || mem_wr || mem_rd) bad++;
    end
    chk(bad == 0, {tag, " R10 no activity"}, bad, 0);
    chk(mem_addr == a0, {tag, " R10 address held"}, mem_addr, a0);
  endtask

  task automatic run_xfer(input bit dir, input logic [AW-1:0] st, input int n, input logic [15:0] s);
    int base, bad, k;
    salt_q = s;
    base = ack_cnt;
    @(negedge clk);
    cfg_load = 1'b1; cfg_dir = dir; cfg_addr = st;
    cfg_cnt = CW'((1 << CW) - n);
    @(negedge clk);
    cfg_load = 1'b0;
    chk(busy == 1'b1, "R2 busy after load", busy, 1);
    chk(irq == 1'b0, "R2 irq cleared by load", irq, 0);
    chk(mem_addr == st, "R2 start address", mem_addr, st);
    for (k = 0; k < n; k++) begin
      strobe_word(data_fn(k, s));
      while (ack_cnt <= base + k) @(negedge clk);
      repeat ($urandom % 3) @(negedge clk);
    end
    wait_idle();
    chk(ack_cnt - base == n, "R6 acknowledge count", ack_cnt - base, n);
    chk(irq == 1'b1, "R8 irq at end", irq, 1);
    chk(busy == 1'b0, "R8 busy cleared", busy, 0);
    chk(mem_addr == exp_addr(st, n), "R6 final address", mem_addr, exp_addr(st, n));
    bad = 0;
    for (int j = 0; j < n; j++) begin
      if (dir == 1'b0) begin
        if (memw[exp_addr(st, j)] !== data_fn(j, s)) begin
          if (bad == 0) chk(1'b0, "R4 memory word", memw[exp_addr(st, j)], data_fn(j, s));
          bad++;
        end
      end else begin
        if (rd_log[(base + j) % 1024] !== mem_fn(exp_addr(st, j), s)) begin
          if (bad == 0) chk(1'b0, "R5 device word", rd_log[(base + j) % 1024], mem_fn(exp_addr(st, j), s));
          bad++;
        end
      end
    end
    if (bad == 0) chk(1'b1, dir ? "R5 data" : "R4 data", 0, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; cfg_load = 1'b0; cfg_dir = 1'b0; cfg_addr = '0; cfg_cnt = '0;
    irq_clr = 1'b0; dev_strobe = 1'b0; dev_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({bus_hold, dev_ack, mem_wr, mem_rd, busy, irq} == 6'b0, "R1 reset outputs",
        {bus_hold, dev_ack, mem_wr, mem_rd, busy, irq}, 0);
    chk(mem_addr == '0, "R1 reset address", mem_addr, 0);

    ignored_strobes("after reset");

    // Single word, device to memory: count 0xFF.
    run_xfer(1'b0, 8'h10, 1, 16'h1111);
    repeat (12) @(negedge clk);
    chk(irq == 1'b1, "R9 irq sticky", irq, 1);
    ignored_strobes("after completion");
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    chk(irq == 1'b0, "R9 irq cleared", irq, 0);

    // Address wraps across the top, memory to device.
    run_xfer(1'b1, 8'hFC, 6, 16'h5A5A);
    // Load while irq still set: load clears it (checked in run_xfer).
    run_xfer(1'b0, 8'hFE, 4, 16'h0F0F);
    // Loaded count of zero moves the full 2^CW words.
    run_xfer(1'b0, 8'h00, 1 << CW, 16'h7777);
    run_xfer(1'b1, 8'h80, 1 << CW, 16'h3C3C);

    for (int i = 0; i < 8; i++) begin
      run_xfer(1'($urandom), AW'($urandom), 1 + ($urandom % 12), 16'($urandom));
    end

    chk(proto_err == 0, "R3 R6 R7 handshake order", proto_err, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule